// File: doc/BRIEF.md
# Pi/4-Shifted QPSK Burst Transmit Sequencer

This block takes a serial transmit bit stream with a window signal and produces, for each symbol period of a burst, a 3-bit phase index on the eight-point pi/4-shifted QPSK constellation together with a 2-bit ramp amplitude code. A downstream pulse-shaping filter and converter turn these into I/Q samples. The bit clock either comes from outside and is resynchronised to the fast clock, or is made inside by dividing the fast clock by ten. Bits are paired into dibits, the first bit being the MSB. Each dibit advances an accumulated phase by an odd multiple of pi/4.

A burst opens when a window-high bit is sampled while the sequencer is idle. It then carries two ramp-up symbols, one data symbol for every complete pair of window-high bits, and two ramp-down symbols. One closing slot follows, in which the burst flag drops. Every output change lags the bit that caused it by a fixed 6.25 symbol periods, which is 125 fast-clock cycles. A modulation-off input freezes the phase at the constellation origin index, while the ramps and the burst timing run as usual.

Top module: `pi4_burst_tx`

## Requirements
- R1: With `clk_sel`=1, `bclk_out` is `clk` divided by 10: it is high for 5 cycles, then low for 5. Each data bit and window bit is sampled at the clock edge on which `bclk_out` rises.
- R2: With `clk_sel`=0, `bclk_in` is resynchronised and repeated on `bclk_out` with the same period. Bits are sampled at the clock edge on which `bclk_out` rises.
- R3: A data dibit {first bit, second bit} adds to the phase, modulo 8, in units of pi/4: 00 adds 1, 01 adds 3, 11 adds 5 and 10 adds 7.
- R4: `ramp_amp` is 1 and then 2 over the two ramp-up symbols, 3 on data symbols, and 2 and then 1 over the two ramp-down symbols. `sym_phase` is set to 0 on the first ramp-up symbol and does not change on ramp symbols.
- R5: A window-high bit sampled while idle opens a burst. Data symbols come from consecutive bit pairs, starting at that opening bit, for as long as both bits of a pair were sampled with the window high. The first pair holding a window-low bit ends the data, and an unpaired last bit is dropped.
- R6: Symbol slots fall every second bit. The first ramp-up is at the opening bit, the second at +2 bits, data symbol k at +2k+4 bits, and the ramp-downs follow the last data slot. Each slot's output appears exactly 125 `clk` cycles after the edge that sampled the slot's bit.
- R7: `sym_stb` is a one-cycle pulse that marks each ramp and data symbol. `sym_phase` changes only with a strobe. `ramp_amp` changes only with a strobe or when `burst` falls.
- R8: `burst` rises with the first ramp-up strobe and falls at the closing slot, two bits after the second ramp-down. While `burst` is low, `ramp_amp` is 0 and no strobe occurs.
- R9: While `mod_off` is 1, data symbols leave `sym_phase` unchanged.
- R10: After reset, `sym_phase`, `ramp_amp`, `sym_stb`, `burst` and `bclk_out` are 0.
- R11: A window-high bit sampled in a burst's closing slot is discarded. The next burst opens at the following window-high bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, ten ticks per bit |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_sel | input | 1 | 1: divide `clk` for the bit clock, 0: use `bclk_in` |
| bclk_in | input | 1 | External bit clock |
| din | input | 1 | Serial transmit data bit |
| win | input | 1 | Transmit window, high for bits that belong to a burst |
| mod_off | input | 1 | 1 freezes the phase on data symbols |
| bclk_out | output | 1 | Bit clock in use; a rising edge marks a sampling edge |
| sym_phase | output | 3 | Phase index in units of pi/4 |
| ramp_amp | output | 2 | Ramp amplitude code, 0 to 3 |
| sym_stb | output | 1 | One-cycle strobe per output symbol |
| burst | output | 1 | High while the burst, including its ramps, is on air |

## Verification
The close of one burst and the opening of the next can fall on the same sampled bit. The bit in the closing slot sees the window high, but the sequencer is still finishing. The bench provokes this by sending a burst, then exactly eight window-low bits, then a second window. The first high bit of the second window lands in the closing slot. The check passes only if that bit is dropped: the second burst's first ramp-up must appear 125 cycles after the following bit, `burst` must stay low for half a symbol in between, and the second burst's data must start from that later bit.

// File: rtl/txs_pkg.sv
// Shared types for the burst transmit sequencer.
// Assumes: slot records travel as packed vectors through the latency line.
package txs_pkg;

    // Kind of symbol slot issued by the framer.
    typedef enum logic [2:0] {
        K_RU0  = 3'd0,
        K_RU1  = 3'd1,
        K_DATA = 3'd2,
        K_RD0  = 3'd3,
        K_RD1  = 3'd4,
        K_END  = 3'd5
    } slot_kind_t;

    // One slot record: valid flag, kind and dibit (first bit in [1]).
    typedef struct packed {
        logic       vld;
        slot_kind_t kind;
        logic [1:0] dibit;
    } slot_rec_t;

    // Phase step in pi/4 units for one dibit.
    function automatic logic [2:0] dibit_step(input logic [1:0] d);
        case (d)
            2'b00:   return 3'd1;
            2'b01:   return 3'd3;
            2'b11:   return 3'd5;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/txs_bitclk.sv
// Bit clock selection: either divides clk by DIV or resynchronises an
// external bit clock. Gives a one-cycle strobe in the cycle before the edge
// on which bclk_out rises; that edge samples the serial inputs.
// Assumes: the external bit clock is much slower than clk.
module txs_bitclk #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sel,
    input  logic bclk_in,
    output logic bclk_out,
    output logic bit_stb
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HI = DIV / 2;
    localparam logic [CW-1:0] CNT_MAX = CW'(DIV - 1);
    localparam logic [CW-1:0] HI_M1   = CW'(HI - 1);

    logic [CW-1:0] cnt_q;
    logic          div_q;
    logic [2:0]    sync_q;

    // Divider counter and its registered clock, high for the first HI counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else begin
            cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
            div_q <= (cnt_q == CNT_MAX) || (cnt_q < HI_M1);
        end
    end

    // Two-flop resynchroniser plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], bclk_in};
    end

    // Source selection for the strobe and the repeated clock.
    always_comb begin
        if (clk_sel) begin
            bit_stb  = (cnt_q == CNT_MAX);
            bclk_out = div_q;
        end else begin
            bit_stb  = sync_q[1] & ~sync_q[2];
            bclk_out = sync_q[2];
        end
    end

endmodule

// File: rtl/txs_framer.sv
// Burst framer: watches sampled bits and the window and issues one slot
// record every second bit while a burst runs: two ramp-ups, data dibits
// taken from a four-bit history, two ramp-downs and a closing slot.
// Assumes: bit_stb is a single-cycle pulse; din/win are stable around it.
module txs_framer
    import txs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_stb,
    input  logic      din,
    input  logic      win,
    output slot_rec_t rec_q
);
    localparam int HIST = 4;

    typedef enum logic [2:0] {F_IDLE, F_RU1, F_DATA, F_RD1, F_END} fr_state_t;

    fr_state_t       st_q, st_d;
    logic            odd_q, odd_d;
    logic [HIST-1:0] hd_q, hw_q;
    slot_rec_t       rec_d;

    // Bit and window history, newest bit in position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hd_q <= '0;
            hw_q <= '0;
        end else if (bit_stb) begin
            hd_q <= {hd_q[HIST-2:0], din};
            hw_q <= {hw_q[HIST-2:0], win};
        end
    end

    // Slot decision for the current strobe.
    always_comb begin
        st_d  = st_q;
        odd_d = odd_q;
        rec_d = '0;
        if (bit_stb) begin
            if (st_q == F_IDLE) begin
                if (win) begin
                    rec_d.vld  = 1'b1;
                    rec_d.kind = K_RU0;
                    st_d       = F_RU1;
                    odd_d      = 1'b1;
                end
            end else if (odd_q) begin
                odd_d = 1'b0;
            end else begin
                odd_d     = 1'b1;
                rec_d.vld = 1'b1;
                case (st_q)
                    F_RU1: begin
                        rec_d.kind = K_RU1;
                        st_d       = F_DATA;
                    end
                    F_DATA: begin
                        if (&hw_q[HIST-1:HIST-2]) begin
                            rec_d.kind  = K_DATA;
                            rec_d.dibit = hd_q[HIST-1:HIST-2];
                        end else begin
                            rec_d.kind = K_RD0;
                            st_d       = F_RD1;
                        end
                    end
                    F_RD1: begin
                        rec_d.kind = K_RD1;
                        st_d       = F_END;
                    end
                    default: begin
                        rec_d.kind = K_END;
                        st_d       = F_IDLE;
                    end
                endcase
            end
        end
    end

    // State, parity and record registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= F_IDLE;
            odd_q <= 1'b0;
            rec_q <= '0;
        end else begin
            st_q  <= st_d;
            odd_q <= odd_d;
            rec_q <= rec_d;
        end
    end

endmodule

// File: rtl/txs_delay.sv
// Fixed latency line: DEPTH register stages of width W, or a wire when
// DEPTH is zero.
// Assumes: DEPTH stays in the low hundreds.
module txs_delay #(
    parameter int DEPTH = 124,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_pipe
            logic [W-1:0] pipe_q [DEPTH];

            // Shift every stage forward by one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
                end else begin
                    pipe_q[0] <= din;
                    for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
                end
            end

            assign dout = pipe_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/txs_mapper.sv
// Output stage: applies delayed slot records to the phase accumulator,
// the ramp code, the symbol strobe and the burst flag.
// Assumes: mod_off is steady while a burst is on air.
module txs_mapper
    import txs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  slot_rec_t rec,
    input  logic      mod_off,
    output logic [2:0] phase_q,
    output logic [1:0] amp_q,
    output logic       stb_q,
    output logic       burst_q
);
    // Record-driven update of all outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            amp_q   <= '0;
            stb_q   <= 1'b0;
            burst_q <= 1'b0;
        end else begin
            stb_q <= rec.vld && (rec.kind != K_END);
            if (rec.vld) begin
                case (rec.kind)
                    K_RU0: begin
                        phase_q <= '0;
                        amp_q   <= 2'd1;
                        burst_q <= 1'b1;
                    end
                    K_RU1:  amp_q <= 2'd2;
                    K_DATA: begin
                        amp_q <= 2'd3;
                        if (!mod_off) phase_q <= phase_q + dibit_step(rec.dibit);
                    end
                    K_RD0:  amp_q <= 2'd2;
                    K_RD1:  amp_q <= 2'd1;
                    default: begin
                        amp_q   <= 2'd0;
                        burst_q <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pi4_burst_tx.sv
// Top of the pi/4-shifted QPSK burst transmit sequencer: bit clock
// selection, burst framing, a fixed 6.25-symbol latency line and the
// phase/ramp output stage.
// Assumes: DIV clk cycles per bit; LAT_QSYM quarter-symbols of latency.
module pi4_burst_tx
    import txs_pkg::*;
#(
    parameter int DIV      = 10,
    parameter int LAT_QSYM = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_sel,
    input  logic       bclk_in,
    input  logic       din,
    input  logic       win,
    input  logic       mod_off,
    output logic       bclk_out,
    output logic [2:0] sym_phase,
    output logic [1:0] ramp_amp,
    output logic       sym_stb,
    output logic       burst
);
    localparam int SYM_TICKS = 2 * DIV;
    localparam int LAT       = (LAT_QSYM * SYM_TICKS) / 4;
    localparam int DLY_DEPTH = LAT - 1;
    localparam int REC_W     = $bits(slot_rec_t);

    logic             bit_stb;
    slot_rec_t        rec_fr;
    logic [REC_W-1:0] rec_late;

    txs_bitclk #(.DIV(DIV)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_sel  (clk_sel),
        .bclk_in  (bclk_in),
        .bclk_out (bclk_out),
        .bit_stb  (bit_stb)
    );

    txs_framer u_frm (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_stb (bit_stb),
        .din     (din),
        .win     (win),
        .rec_q   (rec_fr)
    );

    txs_delay #(.DEPTH(DLY_DEPTH), .W(REC_W)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rec_fr),
        .dout  (rec_late)
    );

    txs_mapper u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rec     (slot_rec_t'(rec_late)),
        .mod_off (mod_off),
        .phase_q (sym_phase),
        .amp_q   (ramp_amp),
        .stb_q   (sym_stb),
        .burst_q (burst)
    );

endmodule

// File: rtl/pi4_burst_tx_chk.sv
// Port-level property checker for pi4_burst_tx, attached by bind.
// Assumes: rst_n is held low for at least two clock cycles.
module pi4_burst_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_sel,
    input logic       bclk_in,
    input logic       din,
    input logic       win,
    input logic       mod_off,
    input logic       bclk_out,
    input logic [2:0] sym_phase,
    input logic [1:0] ramp_amp,
    input logic       sym_stb,
    input logic       burst
);
    // R8
    idle_amp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst |-> ramp_amp == 2'd0);

    // R8
    stb_inside_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb |-> burst);

    // R4
    burst_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst) |-> sym_stb && ramp_amp == 2'd1 && sym_phase == 3'd0);

    // R4
    amp_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst |-> ramp_amp != 2'd0);

    // R7
    phase_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_stb |-> $stable(sym_phase));

    // R7
    amp_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ramp_amp) |-> sym_stb || $fell(burst));

    // R9
    modoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_stb && ramp_amp == 2'd3 && $past(mod_off) |-> $stable(sym_phase));

    // R1
    div_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel && $past(clk_sel) && $rose(bclk_out) |=> bclk_out);

endmodule

bind pi4_burst_tx pi4_burst_tx_chk u_chk (.*);

// File: tb/tb_pi4_burst_tx.sv
`timescale 1ns/1ps
module tb_pi4_burst_tx;
    localparam int LAT  = 125;
    localparam int MAXB = 128;

    logic clk = 1'b0, rst_n = 1'b0, clk_sel = 1'b1, bclk_in = 1'b0;
    logic din = 1'b0, win = 1'b0, mod_off = 1'b0;
    logic bclk_out, sym_stb, burst;
    logic [2:0] sym_phase;
    logic [1:0] ramp_amp;

    always #2.5 clk = ~clk;

    pi4_burst_tx dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .bclk_in(bclk_in),
        .din(din), .win(win), .mod_off(mod_off), .bclk_out(bclk_out),
        .sym_phase(sym_phase), .ramp_amp(ramp_amp), .sym_stb(sym_stb), .burst(burst)
    );

    int n_checks = 0, n_fail = 0;
    int cyc = 0, cur_idx = -1, last_rise = 0, per_last = 0, hi_last = 0;
    logic b_prev = 1'b0, bst_prev = 1'b0;
    int bit_edge [MAXB];
    logic bd [MAXB];
    logic bw [MAXB];
    int blen = 0;
    int o_cyc [64];
    int o_ph [64];
    int o_amp [64];
    int n_obs = 0;
    int fall_cyc [8];
    int n_fall = 0;
    int idle_bad = 0;
    bit done = 1'b0;

    // External bit clock: period of 10 clk cycles.
    int bdiv = 0;
    always @(negedge clk) begin
        bdiv = (bdiv == 4) ? 0 : bdiv + 1;
        if (bdiv == 0) bclk_in = ~bclk_in;
    end

    // Monitor, 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (bclk_out && !b_prev) begin
            if (cur_idx >= 0) bit_edge[cur_idx] = cyc;
            per_last  = cyc - last_rise;
            last_rise = cyc;
        end
        if (!bclk_out && b_prev) hi_last = cyc - last_rise;
        b_prev = bclk_out;
        if (sym_stb && n_obs < 64) begin
            o_cyc[n_obs] = cyc; o_ph[n_obs] = sym_phase; o_amp[n_obs] = ramp_amp;
            n_obs++;
        end
        if (!burst && bst_prev && n_fall < 8) begin
            fall_cyc[n_fall] = cyc; n_fall++;
        end
        if (!burst && (ramp_amp != 2'd0 || sym_stb)) idle_bad++;
        bst_prev = burst;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Phase step per dibit, taken from R3.
    function automatic int step_of(input logic b0, input logic b1);
        case ({b0, b1})
            2'b00:   return 1;
            2'b01:   return 3;
            2'b11:   return 5;
            default: return 7;
        endcase
    endfunction

    // Append n bits; kind 0 random data, 1 fixed pattern 0001 1110.
    task automatic add_bits(input int n, input logic w, input int kind);
        logic [7:0] pat = 8'b0001_1110;
        for (int i = 0; i < n; i++) begin
            bw[blen] = w;
            bd[blen] = (kind == 1) ? pat[7 - (i % 8)] : logic'($urandom_range(0, 1));
            blen++;
        end
    endtask

    task automatic send_stream();
        n_obs = 0; n_fall = 0; idle_bad = 0;
        do @(negedge clk); while (bclk_out);
        for (int i = 0; i < blen; i++) begin
            @(negedge clk);
            din = bd[i]; win = bw[i]; cur_idx = i;
            do @(negedge clk); while (!bclk_out);
            do @(negedge clk); while (bclk_out);
        end
        win = 1'b0; cur_idx = -1;
        repeat (LAT + 60) @(negedge clk);
    endtask

    task automatic expect_sym(input int e, input int slot, input int ph, input int amp, input string tag);
        if (e >= n_obs) begin
            check(1'b0, {tag, " missing symbol"}, n_obs, e + 1);
            return;
        end
        check(o_cyc[e] == bit_edge[slot] + LAT, {tag, " timing"}, o_cyc[e], bit_edge[slot] + LAT);
        check(o_ph[e] == ph && o_amp[e] == amp, {tag, " phase*4+amp"},
              o_ph[e] * 4 + o_amp[e], ph * 4 + amp);
    endtask

    // Expected bursts, built from R4, R5, R6, R8 and R11.
    task automatic check_stream(input bit frozen);
        int e = 0, nb = 0, i = 0, s0, k, ph;
        while (i < blen) begin
            if (!bw[i]) begin i++; continue; end
            s0 = i; ph = 0; k = 0;
            expect_sym(e, s0, 0, 1, "R6 first ramp-up"); e++;
            expect_sym(e, s0 + 2, 0, 2, "R4 second ramp-up"); e++;
            while (s0 + 2*k + 1 < blen && bw[s0 + 2*k] && bw[s0 + 2*k + 1]) begin
                if (!frozen) ph = (ph + step_of(bd[s0 + 2*k], bd[s0 + 2*k + 1])) % 8;
                expect_sym(e, s0 + 2*k + 4, ph, 3, frozen ? "R9 frozen data" : "R3 data phase"); e++;
                k++;
            end
            expect_sym(e, s0 + 2*k + 4, ph, 2, "R4 ramp-down 1"); e++;
            expect_sym(e, s0 + 2*k + 6, ph, 1, "R4 ramp-down 2"); e++;
            if (nb < n_fall)
                check(fall_cyc[nb] == bit_edge[s0 + 2*k + 8] + LAT, "R8 burst fall",
                      fall_cyc[nb], bit_edge[s0 + 2*k + 8] + LAT);
            else
                check(1'b0, "R8 burst fall missing", n_fall, nb + 1);
            nb++;
            i = s0 + 2*k + 9;
        end
        check(n_obs == e, "R5 symbol count", n_obs, e);
        check(n_fall == nb, "R11 burst count", n_fall, nb);
        check(idle_bad == 0, "R8 idle outputs", idle_bad, 0);
    endtask

    task automatic do_reset(input logic sel);
        rst_n = 1'b0; clk_sel = sel;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input bit frozen);
        mod_off = frozen;
        send_stream();
        check_stream(frozen);
        mod_off = 1'b0;
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'h1A2B);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        // R10: reset state
        check(sym_phase == 0 && ramp_amp == 0 && sym_stb == 0 && burst == 0 && bclk_out == 0,
              "R10 reset outputs", {sym_phase, ramp_amp, sym_stb, burst, bclk_out}, 0);
        do_reset(1'b1);

        // R3: every dibit once, in a fixed pattern
        blen = 0; add_bits(3, 0, 0); add_bits(8, 1, 1); add_bits(16, 0, 0); run(0);
        // R1: divided clock shape
        check(per_last == 10, "R1 divided period", per_last, 10);
        check(hi_last == 5, "R1 divided high time", hi_last, 5);

        // R5: single window bit gives ramps only
        blen = 0; add_bits(2, 0, 0); add_bits(1, 1, 0); add_bits(16, 0, 0); run(0);
        // R5: odd window length drops last bit
        blen = 0; add_bits(2, 0, 0); add_bits(7, 1, 0); add_bits(16, 0, 0); run(0);
        // R11: new window lands on the closing slot
        blen = 0; add_bits(2, 0, 0); add_bits(6, 1, 0); add_bits(8, 0, 0);
        add_bits(7, 1, 0); add_bits(16, 0, 0); run(0);
        // R3 / R6: random bursts
        for (int r = 0; r < 4; r++) begin
            blen = 0; add_bits($urandom_range(1, 4), 0, 0);
            add_bits($urandom_range(2, 40), 1, 0); add_bits(16, 0, 0); run(0);
        end
        // R9: modulation off
        blen = 0; add_bits(2, 0, 0); add_bits(20, 1, 0); add_bits(16, 0, 0); run(1);

        // R2: external bit clock
        do_reset(1'b0);
        blen = 0; add_bits(3, 0, 0); add_bits(16, 1, 0); add_bits(16, 0, 0); run(0);
        check(per_last == 10, "R2 external period", per_last, 10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule